// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two IEEE 754 binary32 operands and returns the binary32 sum together with four exception flags: invalid operation, overflow, underflow and inexact. A caller presents both operands, a two-bit rounding-mode code and a valid strobe. One clock later the registered sum appears with its own valid strobe. Subtraction is done by the caller, who inverts the sign bit of the second operand before it enters the block.

Each operand is first sorted into one of six classes: signalling NaN, quiet NaN, infinity, zero, normal or subnormal. Pairs that involve a NaN, an infinity or a zero are answered by a fixed selection table and never reach the datapath. Finite nonzero pairs go through subnormal pre-normalisation, exponent alignment with three extra low bits (guard, round, sticky), a magnitude add or subtract, normalisation, and rounding back to binary32. Rounding handles gradual underflow and saturation on overflow.

Top module: `fp32_adder`

## Requirements
- R1: A signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear) in op_a yields op_a with fraction bit 22 set. If op_a is not a signalling NaN, a signalling NaN in op_b yields op_b quieted the same way. Either case raises invalid. A signalling NaN in op_b wins over a quiet NaN in op_a.
- R2: If neither operand is a signalling NaN, a quiet NaN in op_a is returned bit for bit. Otherwise a quiet NaN in op_b is returned bit for bit. No flag is raised.
- R3: Two infinities of the same sign return that infinity. Two infinities of opposite sign return 0x7FC00000 and raise invalid. An infinity plus any finite operand returns the infinity unchanged, with no flag.
- R4: A finite nonzero operand plus a zero returns the nonzero operand unchanged. Two zeros of the same sign return op_a. Two zeros of opposite sign return +0, or -0 when rnd_mode is 3.
- R5: Finite sums, including sums with subnormal operands and subnormal results, are correctly rounded under rnd_mode 0 (round to nearest, ties to even).
- R6: rnd_mode 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity.
- R7: An exact cancellation of finite nonzero operands returns +0, or -0 when rnd_mode is 3, with no flag.
- R8: On overflow, overflow and inexact are both raised. The result is the correctly signed infinity in mode 0, and in mode 2 for positive sums or mode 3 for negative sums. Otherwise the result is the largest finite magnitude with the sum's sign.
- R9: Inexact is raised exactly when the rounded result differs from the exact sum.
- R10: Underflow is raised only when a result is below the normal range before rounding and is also inexact. An exact subnormal result raises no underflow.
- R11: A sum and its flags appear on the outputs one clock after in_valid is sampled high, with out_valid high for that one cycle. Without in_valid the outputs hold their values and out_valid is low. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Registered sum is valid |
| sum_out | output | 32 | Registered binary32 sum |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Overflow |
| flag_underflow | output | 1 | Underflow |
| flag_inexact | output | 1 | Inexact result |

## Verification
Sums of like sign are tried with and without a carry out of the significand, which separates the carry renormalisation from the plain path. Sums of unlike sign are tried with one-bit normalisation, with full cancellation, and with a tiny operand that reaches only the sticky bit. Comparing the outcomes across all four rounding modes shows whether ties, sticky-only discards and sign-dependent directed rounding are each resolved correctly. Subnormal operand pairs test pre-normalisation and the handling of subnormal and boundary results. Each NaN, infinity and zero pairing is applied in both operand orders to confirm the selection priority.

// File: rtl/fp32_adder_pkg.sv
// Package: shared widths, operand class, rounding modes and flag bundle
// for the binary32 adder. Assumes IEEE 754 binary32 layout.
package fp32_adder_pkg;
    localparam int EXP_W  = 8;                  // exponent field width
    localparam int FRAC_W = 23;                 // stored fraction width
    localparam int WORD_W = 1 + EXP_W + FRAC_W; // packed word width
    localparam int SIG_W  = FRAC_W + 1;         // significand incl. hidden bit
    localparam int GRS_W  = 3;                  // guard, round, sticky
    localparam int WRK_W  = SIG_W + GRS_W;      // aligned working width
    localparam int ESW    = EXP_W + 2;          // signed working exponent
    localparam int EXP_MAX = (1 << EXP_W) - 1;  // all-ones exponent code

    localparam logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
    } fp_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0, RM_ZERO = 2'd1, RM_UP = 2'd2, RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } fp_flags_t;

    typedef struct packed {
        logic                   sign;
        logic signed [ESW-1:0]  exp;   // biased, may go below 1 for subnormals
        logic [SIG_W-1:0]       sig;   // hidden bit at MSB for finite nonzero
        fp_class_e              cls;
    } fp_unpacked_t;
endpackage

// File: rtl/fp32_unpack.sv
// Unpack: classifies one binary32 word and, for finite nonzero values,
// returns a significand with the hidden bit set and a matching exponent.
// Assumes nothing about the operand; subnormals get exponent 1-shift.
module fp32_unpack
    import fp32_adder_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_unpacked_t      unp
);
    localparam int LZW = $clog2(SIG_W + 1);

    logic [EXP_W-1:0]  efld;
    logic [FRAC_W-1:0] ffld;
    logic [LZW-1:0]    sub_lz;

    // Position of the highest set bit, as a count of leading zeros.
    function automatic logic [LZW-1:0] lead_zeros(input logic [SIG_W-1:0] v);
        lead_zeros = LZW'(SIG_W);
        for (int i = 0; i < SIG_W; i++)
            if (v[i]) lead_zeros = LZW'(SIG_W - 1 - i);
    endfunction

    assign efld   = word[WORD_W-2 -: EXP_W];
    assign ffld   = word[FRAC_W-1:0];
    assign sub_lz = lead_zeros({1'b0, ffld});

    // Class decode and subnormal pre-normalisation.
    always_comb begin
        unp.sign = word[WORD_W-1];
        unp.sig  = {1'b1, ffld};
        unp.exp  = ESW'(efld);
        if (efld == EXP_W'(EXP_MAX)) begin
            if (ffld == '0)             unp.cls = CLS_INF;
            else if (ffld[FRAC_W-1])    unp.cls = CLS_QNAN;
            else                        unp.cls = CLS_SNAN;
        end else if (efld == '0) begin
            if (ffld == '0) begin
                unp.cls = CLS_ZERO;
            end else begin
                unp.cls = CLS_SUB;
                unp.sig = {1'b0, ffld} << sub_lz;
                unp.exp = ESW'(1) - ESW'(sub_lz);
            end
        end else begin
            unp.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fp32_special.sv
// Special-case selector: answers every pair that contains a NaN, an
// infinity or a zero. hit low means the datapath result must be used.
// Assumes both operands have already been classified.
module fp32_special
    import fp32_adder_pkg::*;
(
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  fp_class_e         a_cls,
    input  fp_class_e         b_cls,
    input  rmode_e            rm,
    output logic              hit,
    output logic [WORD_W-1:0] res,
    output fp_flags_t         flags
);
    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);

    logic same_sign;
    assign same_sign = (a_word[WORD_W-1] == b_word[WORD_W-1]);

    // Fixed priority: sNaN a, sNaN b, qNaN a, qNaN b, infinities, zeros.
    always_comb begin
        hit   = 1'b1;
        res   = '0;
        flags = '0;
        if (a_cls == CLS_SNAN) begin
            res = a_word | QUIET_BIT;
            flags.invalid = 1'b1;
        end else if (b_cls == CLS_SNAN) begin
            res = b_word | QUIET_BIT;
            flags.invalid = 1'b1;
        end else if (a_cls == CLS_QNAN) begin
            res = a_word;
        end else if (b_cls == CLS_QNAN) begin
            res = b_word;
        end else if (a_cls == CLS_INF && b_cls == CLS_INF) begin
            if (same_sign) begin
                res = a_word;
            end else begin
                res = DEFAULT_NAN;
                flags.invalid = 1'b1;
            end
        end else if (a_cls == CLS_INF) begin
            res = a_word;
        end else if (b_cls == CLS_INF) begin
            res = b_word;
        end else if (a_cls == CLS_ZERO && b_cls == CLS_ZERO) begin
            res = same_sign ? a_word : {rm == RM_DOWN, {(WORD_W-1){1'b0}}};
        end else if (a_cls == CLS_ZERO) begin
            res = b_word;
        end else if (b_cls == CLS_ZERO) begin
            res = a_word;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fp32_addsub.sv
// Magnitude datapath: orders the operands by magnitude, aligns the smaller
// with a sticky bit, adds or subtracts, and normalises so that the top bit
// of the working value is set. Assumes finite nonzero pre-normalised inputs.
module fp32_addsub
    import fp32_adder_pkg::*;
(
    input  logic                  a_sign,
    input  logic signed [ESW-1:0] a_exp,
    input  logic [SIG_W-1:0]      a_sig,
    input  logic                  b_sign,
    input  logic signed [ESW-1:0] b_exp,
    input  logic [SIG_W-1:0]      b_sig,
    output logic                  r_sign,
    output logic signed [ESW-1:0] r_exp,
    output logic [WRK_W-1:0]      r_sig,
    output logic                  r_zero
);
    localparam int LZW = $clog2(WRK_W + 1);

    logic                  swap;
    logic signed [ESW-1:0] big_e, ediff;
    logic [WRK_W-1:0]      big_w, sml_w, aligned, diff;
    logic [WRK_W:0]        sum;
    logic [LZW-1:0]        nlz;

    // Leading zero count of the working value.
    function automatic logic [LZW-1:0] lead_zeros(input logic [WRK_W-1:0] v);
        lead_zeros = LZW'(WRK_W);
        for (int i = 0; i < WRK_W; i++)
            if (v[i]) lead_zeros = LZW'(WRK_W - 1 - i);
    endfunction

    // Order operands so that the larger magnitude is the reference.
    always_comb begin
        swap  = (b_exp > a_exp) || ((b_exp == a_exp) && (b_sig > a_sig));
        big_e = swap ? b_exp : a_exp;
        big_w = {(swap ? b_sig : a_sig), {GRS_W{1'b0}}};
        sml_w = {(swap ? a_sig : b_sig), {GRS_W{1'b0}}};
        ediff = swap ? (b_exp - a_exp) : (a_exp - b_exp);
        r_sign = swap ? b_sign : a_sign;
    end

    // Right shift of the smaller operand, folding lost bits into sticky.
    always_comb begin
        if (ediff >= ESW'(WRK_W))
            aligned = {{(WRK_W-1){1'b0}}, |sml_w};
        else
            aligned = (sml_w >> ediff)
                    | {{(WRK_W-1){1'b0}}, |(sml_w & ~({WRK_W{1'b1}} << ediff))};
    end

    assign sum  = {1'b0, big_w} + {1'b0, aligned};
    assign diff = big_w - aligned;
    assign nlz  = lead_zeros(diff);

    // Effective add with carry renormalisation, or subtract with left shift.
    always_comb begin
        r_zero = 1'b0;
        if (a_sign == b_sign) begin
            if (sum[WRK_W]) begin
                r_sig = {sum[WRK_W:2], sum[1] | sum[0]};
                r_exp = big_e + ESW'(1);
            end else begin
                r_sig = sum[WRK_W-1:0];
                r_exp = big_e;
            end
        end else begin
            r_zero = (diff == '0);
            r_sig  = diff << nlz;
            r_exp  = big_e - ESW'(nlz);
        end
    end
endmodule

// File: rtl/fp32_round.sv
// Rounder: denormalises results below the normal range, rounds per mode
// using guard/round/sticky, and saturates or goes to infinity on overflow.
// Assumes the top bit of sig is set on entry.
module fp32_round
    import fp32_adder_pkg::*;
(
    input  logic                  sign,
    input  logic signed [ESW-1:0] exp,
    input  logic [WRK_W-1:0]      sig,
    input  rmode_e                rm,
    output logic [WORD_W-1:0]     res,
    output fp_flags_t             flags
);
    localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    logic                  tiny, huge, lost, inc, ovf, to_inf;
    logic signed [ESW-1:0] sh;
    logic [WRK_W-1:0]      md;
    logic [EXP_W-1:0]      efld;
    logic [WORD_W-1:0]     rounded;

    // Gradual underflow: shift right to the subnormal position with sticky.
    always_comb begin
        tiny = (exp <= ESW'(0));
        huge = (exp >= ESW'(EXP_MAX));
        sh   = ESW'(1) - exp;
        if (!tiny)
            md = sig;
        else if (sh >= ESW'(WRK_W))
            md = {{(WRK_W-1){1'b0}}, |sig};
        else
            md = (sig >> sh)
               | {{(WRK_W-1){1'b0}}, |(sig & ~({WRK_W{1'b1}} << sh))};
        efld = tiny ? EXP_W'(md[WRK_W-1]) : exp[EXP_W-1:0];
    end

    // Round increment from the mode and the discarded bits.
    always_comb begin
        lost = |md[GRS_W-1:0];
        case (rm)
            RM_NEAREST: inc = md[GRS_W-1] & (|md[GRS_W-2:0] | md[GRS_W]);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = lost & ~sign;
            default:    inc = lost & sign;
        endcase
        rounded = {1'b0, efld, md[WRK_W-2:GRS_W]} + WORD_W'(inc);
    end

    // Overflow handling and flag assembly.
    always_comb begin
        ovf    = huge || (rounded[WORD_W-2 -: EXP_W] == EXP_W'(EXP_MAX));
        to_inf = (rm == RM_NEAREST) || (rm == RM_UP && !sign) || (rm == RM_DOWN && sign);
        flags.invalid   = 1'b0;
        flags.overflow  = ovf;
        flags.inexact   = lost | ovf;
        flags.underflow = tiny & lost;
        if (ovf)
            res = {sign, to_inf ? INF_MAG : MAX_MAG};
        else
            res = {sign, rounded[WORD_W-2:0]};
    end
endmodule

// File: rtl/fp32_adder.sv
// Top: binary32 adder with one register stage. Classifies both operands,
// picks the special-case answer or the rounded datapath answer, and
// registers sum and flags on in_valid. Synchronous active-low reset.
module fp32_adder
    import fp32_adder_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [1:0]  rnd_mode,
    output logic        out_valid,
    output logic [31:0] sum_out,
    output logic        flag_invalid,
    output logic        flag_overflow,
    output logic        flag_underflow,
    output logic        flag_inexact
);
    rmode_e                rm;
    fp_unpacked_t          ua, ub;
    logic                  sp_hit, ar_sign, ar_zero;
    logic [WORD_W-1:0]     sp_res, rd_res, nxt_res;
    fp_flags_t             sp_flags, rd_flags, nxt_flags;
    logic signed [ESW-1:0] ar_exp;
    logic [WRK_W-1:0]      ar_sig;

    assign rm = rmode_e'(rnd_mode);

    fp32_unpack u_unpack_a (.word(op_a), .unp(ua));
    fp32_unpack u_unpack_b (.word(op_b), .unp(ub));

    fp32_special u_special (
        .a_word(op_a), .b_word(op_b), .a_cls(ua.cls), .b_cls(ub.cls),
        .rm(rm), .hit(sp_hit), .res(sp_res), .flags(sp_flags)
    );

    fp32_addsub u_addsub (
        .a_sign(ua.sign), .a_exp(ua.exp), .a_sig(ua.sig),
        .b_sign(ub.sign), .b_exp(ub.exp), .b_sig(ub.sig),
        .r_sign(ar_sign), .r_exp(ar_exp), .r_sig(ar_sig), .r_zero(ar_zero)
    );

    fp32_round u_round (
        .sign(ar_sign), .exp(ar_exp), .sig(ar_sig), .rm(rm),
        .res(rd_res), .flags(rd_flags)
    );

    // Select special answer, exact cancellation zero, or rounded sum.
    always_comb begin
        if (sp_hit) begin
            nxt_res   = sp_res;
            nxt_flags = sp_flags;
        end else if (ar_zero) begin
            nxt_res   = {rm == RM_DOWN, {(WORD_W-1){1'b0}}};
            nxt_flags = '0;
        end else begin
            nxt_res   = rd_res;
            nxt_flags = rd_flags;
        end
    end

    // Output register: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            sum_out        <= '0;
            flag_invalid   <= 1'b0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
            flag_inexact   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_out        <= nxt_res;
                flag_invalid   <= nxt_flags.invalid;
                flag_overflow  <= nxt_flags.overflow;
                flag_underflow <= nxt_flags.underflow;
                flag_inexact   <= nxt_flags.inexact;
            end
        end
    end

    assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_out));
    assert_invalid_is_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> (sum_out[30:22] == 9'h1FF));
    assert_overflow_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_overflow) |-> flag_inexact);
    assert_overflow_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_overflow) |->
        (sum_out[30:0] == 31'h7F80_0000 || sum_out[30:0] == 31'h7F7F_FFFF));
    assert_underflow_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_underflow) |-> flag_inexact);
endmodule

// File: tb/fp32_adder_bench.sv
// Bench: walks a vector table, then directed reset and hold checks.
module fp32_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [31:0] sum_out;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fp32_adder u_fp32_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .sum_out(sum_out),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
    );

    // Row: {req, mode, a, b, expected sum, flags {inv,ovf,unf,inx}}
    localparam int NV = 46;
    localparam logic [105:0] VEC [0:NV-1] = '{
        {4'd5,  2'd0, 32'h3F800000, 32'h3F800000, 32'h40000000, 4'h0}, // R5
        {4'd9,  2'd0, 32'h3F800000, 32'h33800000, 32'h3F800000, 4'h1}, // R9 tie to even
        {4'd6,  2'd2, 32'h3F800000, 32'h33800000, 32'h3F800001, 4'h1}, // R6
        {4'd5,  2'd0, 32'h3F800001, 32'h33800000, 32'h3F800002, 4'h1}, // R5 tie odd
        {4'd6,  2'd1, 32'h3F800001, 32'h33800000, 32'h3F800001, 4'h1}, // R6
        {4'd6,  2'd3, 32'hBF800000, 32'hB3800000, 32'hBF800001, 4'h1}, // R6
        {4'd6,  2'd2, 32'hBF800000, 32'hB3800000, 32'hBF800000, 4'h1}, // R6
        {4'd7,  2'd0, 32'h3F800000, 32'hBF800000, 32'h00000000, 4'h0}, // R7
        {4'd7,  2'd3, 32'h3F800000, 32'hBF800000, 32'h80000000, 4'h0}, // R7
        {4'd7,  2'd2, 32'hBF800000, 32'h3F800000, 32'h00000000, 4'h0}, // R7
        {4'd5,  2'd0, 32'h3FC00000, 32'hBF800000, 32'h3F000000, 4'h0}, // R5
        {4'd5,  2'd0, 32'h3F800000, 32'hBFC00000, 32'hBF000000, 4'h0}, // R5
        {4'd10, 2'd0, 32'h00000001, 32'h00000001, 32'h00000002, 4'h0}, // R10
        {4'd10, 2'd0, 32'h00800000, 32'h80000001, 32'h007FFFFF, 4'h0}, // R10
        {4'd5,  2'd0, 32'h00400000, 32'h00400000, 32'h00800000, 4'h0}, // R5
        {4'd8,  2'd0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 4'h5}, // R8
        {4'd8,  2'd1, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, 4'h5}, // R8
        {4'd8,  2'd2, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 4'h5}, // R8
        {4'd8,  2'd3, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, 4'h5}, // R8
        {4'd8,  2'd3, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 4'h5}, // R8
        {4'd8,  2'd2, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF7FFFFF, 4'h5}, // R8
        {4'd8,  2'd0, 32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 4'h5}, // R8 via rounding
        {4'd1,  2'd0, 32'h7F800001, 32'h7FC00005, 32'h7FC00001, 4'h8}, // R1
        {4'd1,  2'd0, 32'hFFA00000, 32'h3F800000, 32'hFFE00000, 4'h8}, // R1
        {4'd1,  2'd0, 32'h3F800000, 32'h7F800003, 32'h7FC00003, 4'h8}, // R1
        {4'd1,  2'd0, 32'h7FC00005, 32'h7F800001, 32'h7FC00001, 4'h8}, // R1
        {4'd2,  2'd0, 32'h7FC12345, 32'hFFC00001, 32'h7FC12345, 4'h0}, // R2
        {4'd2,  2'd0, 32'h3F800000, 32'hFFC00001, 32'hFFC00001, 4'h0}, // R2
        {4'd3,  2'd0, 32'h7F800000, 32'h7F800000, 32'h7F800000, 4'h0}, // R3
        {4'd3,  2'd0, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 4'h8}, // R3
        {4'd3,  2'd0, 32'hFF800000, 32'h3F800000, 32'hFF800000, 4'h0}, // R3
        {4'd3,  2'd0, 32'h00000001, 32'h7F800000, 32'h7F800000, 4'h0}, // R3
        {4'd4,  2'd0, 32'h80000000, 32'h80000000, 32'h80000000, 4'h0}, // R4
        {4'd4,  2'd0, 32'h00000000, 32'h80000000, 32'h00000000, 4'h0}, // R4
        {4'd4,  2'd3, 32'h00000000, 32'h80000000, 32'h80000000, 4'h0}, // R4
        {4'd4,  2'd2, 32'h80000000, 32'h00000000, 32'h00000000, 4'h0}, // R4
        {4'd4,  2'd0, 32'h80000001, 32'h00000000, 32'h80000001, 4'h0}, // R4
        {4'd4,  2'd0, 32'h00000000, 32'h3F800000, 32'h3F800000, 4'h0}, // R4
        {4'd9,  2'd0, 32'h3F800000, 32'hB3800000, 32'h3F7FFFFF, 4'h0}, // R9 exact
        {4'd9,  2'd0, 32'h3F800000, 32'hB3000000, 32'h3F800000, 4'h1}, // R9
        {4'd9,  2'd0, 32'h3F800000, 32'h00000001, 32'h3F800000, 4'h1}, // R9 sticky only
        {4'd6,  2'd2, 32'h3F800000, 32'h00000001, 32'h3F800001, 4'h1}, // R6
        {4'd6,  2'd1, 32'h3F800000, 32'h80000001, 32'h3F7FFFFF, 4'h1}, // R6
        {4'd5,  2'd0, 32'h40400000, 32'h3F800000, 32'h40800000, 4'h0}, // R5
        {4'd5,  2'd0, 32'h3F800001, 32'h3F800000, 32'h40000000, 4'h1}, // R5 carry tie
        {4'd6,  2'd2, 32'h3F800001, 32'h3F800000, 32'h40000001, 4'h1}  // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset outputs", {out_valid, flag_invalid, flag_overflow, flag_underflow,
              flag_inexact, 27'd0} | {5'd0, 27'd0}, 32'd0);
        check("R11 reset sum", sum_out, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [105:0] row;
            row      = VEC[i];
            rnd_mode = row[101:100];
            op_a     = row[99:68];
            op_b     = row[67:36];
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d sum", row[105:102], i), sum_out, row[35:4]);
            check($sformatf("R%0d vec%0d flags", row[105:102], i),
                  {28'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
                  {28'd0, row[3:0]});
            check($sformatf("R11 vec%0d out_valid", i), {31'd0, out_valid}, 32'd1);
            in_valid = 1'b0;
        end

        // R11 hold: new operands without in_valid leave outputs unchanged
        held = sum_out;
        op_a = 32'h40A00000;
        op_b = 32'h40A00000;
        @(negedge clk);
        check("R11 idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 idle hold", sum_out, held);

        // R11 one-cycle latency then back to idle
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 latency sum", sum_out, 32'h41200000);
        check("R11 latency valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R11 valid drops", {31'd0, out_valid}, 32'd0);

        // R11 reset mid-run clears the registered sum
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears sum", sum_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule